// File: doc/BRIEF.md
# Auto-Incrementing Indirect RAM Access Port

This block gives a CPU register bus access to three small buffers of a queued serial engine through two registers. A 16-bit pointer register holds a 6-bit address. A 16-bit data-port register reads or writes the entry that the pointer selects. Every completed data-port access moves the pointer on by one, so software can stream a whole buffer through one register.

The pointer space has four regions of sixteen entries each. The transmit buffer sits at 0x00–0x0F, the receive buffer at 0x10–0x1F and the command buffer at 0x20–0x2F. The region at 0x30–0x3F is reserved. The command buffer is byte-wide and lives in the upper byte lane of the data word. Each command byte carries a chip-select field and a transfer-command field. The engine side has two combinational read ports, one on the transmit buffer and one on the command buffer, and one write port into the receive buffer. The engine cannot write the command buffer.

The bus is a single-request interface: `bus_sel` holds a request and the request completes on a clock edge where `bus_ready` is high. Writes and pointer reads complete without a wait. Data-port reads complete with exactly one wait state.

Top module: `qram_port`

## Requirements
- R1: `bus_reg`=0 selects the pointer register. Its read value is the 6-bit pointer in bits 5..0, with bits 15..6 reading zero. A write loads the pointer from bits 5..0 of `bus_wdata` and ignores the upper bits.
- R2: Pointer bits 5..4 select the region: 0 is transmit, 1 is receive, 2 is command, 3 is reserved. Bits 3..0 select the entry. Transmit entries written by the CPU appear on `eng_tx_data`. Receive entries written by the engine or the CPU read back at 0x10+entry.
- R3: A data-port write (`bus_reg`=1) stores `bus_wdata` into the selected entry, and the pointer then advances by one.
- R4: A data-port read returns the selected entry, and the pointer advances by exactly one per completed access.
- R5: A data-port read holds `bus_ready` low in its first cycle and completes in the second cycle with `bus_rdata` valid. Writes and pointer reads keep `bus_ready` high.
- R6: In the command region, a write stores only `bus_wdata[15:8]`. A read returns that byte in bits 15..8 and zero in bits 7..0. `eng_cmd_data` shows the stored byte.
- R7: A write to the reserved region is discarded, and a read from it returns zero. The pointer still advances in both cases.
- R8: The pointer wraps from 0x3F to 0x00.
- R9: After reset the pointer reads 0 and the data-port register value on `bus_rdata` with `bus_reg`=1 is 0.
- R10: When the engine's receive write and a CPU access hit the same receive entry in one cycle, the engine value wins. A CPU read whose capture cycle coincides with that write returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 1 | 0 = pointer register, 1 = data port |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bus_ready | output | 1 | Access completes on this edge |
| eng_tx_addr | input | 4 | Engine transmit read index |
| eng_tx_data | output | 16 | Engine transmit read data |
| eng_cmd_addr | input | 4 | Engine command read index |
| eng_cmd_data | output | 8 | Engine command byte |
| eng_rx_we | input | 1 | Engine receive write enable |
| eng_rx_addr | input | 4 | Engine receive write index |
| eng_rx_wdata | input | 16 | Engine receive write data |

## Verification
The hardest case to reach from the ports is the same-entry collision, where an engine receive write lands exactly in the wait cycle of a CPU read of that entry. The bench first stores a known old value through the CPU. It then points at that entry and raises the engine write on the same falling edge that opens the read. A stale capture and a forwarded capture therefore differ at the port. The reserved-region and wrap cases are reached by loading the pointer with 0x3F before a write, so that one access covers both the discard and the wrap.

// File: rtl/qram_port.sv
module qram_port #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic                     bus_reg,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  output logic                     bus_ready,
  input  logic [$clog2(DEPTH)-1:0] eng_tx_addr,
  output logic [DW-1:0]            eng_tx_data,
  input  logic [$clog2(DEPTH)-1:0] eng_cmd_addr,
  output logic [DW/2-1:0]          eng_cmd_data,
  input  logic                     eng_rx_we,
  input  logic [$clog2(DEPTH)-1:0] eng_rx_addr,
  input  logic [DW-1:0]            eng_rx_wdata
);
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 2;
  localparam int CW = DW / 2;

  logic [PW-1:0] ptr;
  logic          rd_wait;
  logic [DW-1:0] data_q;
  logic [DW-1:0] fetch;
  logic [DW-1:0] tx_mem  [DEPTH];
  logic [DW-1:0] rx_mem  [DEPTH];
  logic [CW-1:0] cmd_mem [DEPTH];

  wire [1:0]    bank    = ptr[PW-1:PW-2];
  wire [IW-1:0] idx     = ptr[IW-1:0];
  wire          data_rd = bus_sel & ~bus_wr & bus_reg;
  wire          done    = bus_sel & bus_ready;
  wire          dwrite  = done & bus_wr & bus_reg;
  wire          rx_hit  = eng_rx_we && (eng_rx_addr == idx);

  assign bus_ready    = ~(data_rd & ~rd_wait);
  assign bus_rdata    = bus_reg ? data_q : {{(DW-PW){1'b0}}, ptr};
  assign eng_tx_data  = tx_mem[eng_tx_addr];
  assign eng_cmd_data = cmd_mem[eng_cmd_addr];

  always_comb begin
    case (bank)
      2'd0:    fetch = tx_mem[idx];
      2'd1:    fetch = rx_hit ? eng_rx_wdata : rx_mem[idx];
      2'd2:    fetch = {cmd_mem[idx], {CW{1'b0}}};
      default: fetch = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      rd_wait <= 1'b0;
      data_q  <= '0;
    end else begin
      rd_wait <= data_rd & ~rd_wait;
      if (data_rd & ~rd_wait) data_q <= fetch;
      else if (dwrite)        data_q <= bus_wdata;
      if (done) begin
        if (bus_reg)     ptr <= ptr + 1'b1;
        else if (bus_wr) ptr <= bus_wdata[PW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dwrite) begin
      case (bank)
        2'd0:    tx_mem[idx]  <= bus_wdata;
        2'd1:    rx_mem[idx]  <= bus_wdata;
        2'd2:    cmd_mem[idx] <= bus_wdata[DW-1:CW];
        default: ;
      endcase
    end
    if (eng_rx_we) rx_mem[eng_rx_addr] <= eng_rx_wdata;
  end
endmodule

module qram_port_chk #(
  parameter int DW = 16,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          wr,
  input logic          regd,
  input logic          ready,
  input logic [DW-1:0] rdata,
  input logic [PW-1:0] ptr
);
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && regd && ready) |=> ptr == PW'($past(ptr) + 1'b1));

  assert_write_no_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr) |-> ready);

  assert_read_one_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && regd && !ready) ##1 (sel && !wr && regd) |-> ready);

  assert_ptr_hi_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !regd) |-> rdata[DW-1:PW] == '0);

  assert_cmd_lo_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && regd && !ready && ptr[PW-1:PW-2] == 2'd2) ##1 (sel && !wr && regd)
      |-> rdata[DW/2-1:0] == '0);

  assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && regd && !ready && ptr[PW-1:PW-2] == 2'd3) ##1 (sel && !wr && regd)
      |-> rdata == '0);

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && regd && ready && ptr == '1) |=> ptr == '0);
endmodule

bind qram_port qram_port_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .regd(bus_reg),
  .ready(bus_ready), .rdata(bus_rdata), .ptr(ptr)
);

// File: tb/sim_qram_port.sv
module sim_qram_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 37;

  // {op, req, wdata, expected}: op 0 ptr write, 1 data write, 2 ptr read, 3 data read
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 4'd1,  16'h0000, 16'h0000},
    {2'd1, 4'd3,  16'h1234, 16'h0000},  // R3
    {2'd1, 4'd3,  16'hABCD, 16'h0000},
    {2'd2, 4'd3,  16'h0000, 16'h0002},
    {2'd0, 4'd1,  16'h0000, 16'h0000},
    {2'd3, 4'd4,  16'h0000, 16'h1234},  // R4
    {2'd3, 4'd4,  16'h0000, 16'hABCD},
    {2'd0, 4'd1,  16'h0020, 16'h0000},
    {2'd1, 4'd6,  16'hA5FF, 16'h0000},  // R6
    {2'd0, 4'd1,  16'h0020, 16'h0000},
    {2'd3, 4'd6,  16'h0000, 16'hA500},
    {2'd2, 4'd6,  16'h0000, 16'h0021},
    {2'd0, 4'd1,  16'h0030, 16'h0000},
    {2'd1, 4'd7,  16'hFFFF, 16'h0000},  // R7
    {2'd2, 4'd7,  16'h0000, 16'h0031},
    {2'd0, 4'd1,  16'h0030, 16'h0000},
    {2'd3, 4'd7,  16'h0000, 16'h0000},
    {2'd0, 4'd1,  16'h000F, 16'h0000},
    {2'd1, 4'd3,  16'h0F0F, 16'h0000},
    {2'd2, 4'd2,  16'h0000, 16'h0010},  // R2
    {2'd1, 4'd2,  16'h7777, 16'h0000},
    {2'd0, 4'd1,  16'h0010, 16'h0000},
    {2'd3, 4'd2,  16'h0000, 16'h7777},
    {2'd0, 4'd1,  16'h003F, 16'h0000},
    {2'd1, 4'd7,  16'h5555, 16'h0000},
    {2'd2, 4'd8,  16'h0000, 16'h0000},  // R8
    {2'd0, 4'd1,  16'h003F, 16'h0000},
    {2'd3, 4'd7,  16'h0000, 16'h0000},
    {2'd2, 4'd8,  16'h0000, 16'h0000},
    {2'd0, 4'd1,  16'h000F, 16'h0000},
    {2'd3, 4'd2,  16'h0000, 16'h0F0F},
    {2'd0, 4'd1,  16'hFFC5, 16'h0000},  // R1
    {2'd2, 4'd1,  16'h0000, 16'h0005},
    {2'd0, 4'd1,  16'h002F, 16'h0000},
    {2'd1, 4'd6,  16'h1200, 16'h0000},
    {2'd0, 4'd1,  16'h002F, 16'h0000},
    {2'd3, 4'd6,  16'h0000, 16'h1200}
  };

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0, bus_reg = 0;
  logic [15:0] bus_wdata = '0, bus_rdata, eng_tx_data, eng_rx_wdata = '0;
  logic        bus_ready, eng_rx_we = 0;
  logic [3:0]  eng_tx_addr = '0, eng_cmd_addr = '0, eng_rx_addr = '0;
  logic [7:0]  eng_cmd_data;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qram_port u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_op(input logic r, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_reg = r; bus_wdata = d;
    @(posedge clk);
  endtask

  task automatic rd_op(input logic r, input logic [15:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_reg = r;
    #1;
    if (r) begin
      check(bus_ready == 1'b0, "R5 wait state", {15'd0, bus_ready}, 16'd0);
      @(posedge clk); @(negedge clk); #1;
    end
    check(bus_ready == 1'b1, "R5 ready", {15'd0, bus_ready}, 16'd1);
    check(bus_rdata == e, tag, bus_rdata, e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; bus_reg = 0; #1;
    check(bus_rdata == 16'h0000, "R9 pointer reset", bus_rdata, 16'h0000);
    check(bus_ready == 1'b1, "R9 idle ready", {15'd0, bus_ready}, 16'd1);
    bus_reg = 1; #1;
    check(bus_rdata == 16'h0000, "R9 data register reset", bus_rdata, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] rq;
      logic [15:0] d, e;
      {op, rq, d, e} = VEC[i];
      case (op)
        2'd0: wr_op(1'b0, d);
        2'd1: wr_op(1'b1, d);
        2'd2: rd_op(1'b0, e, $sformatf("R%0d vector %0d", rq, i));
        default: rd_op(1'b1, e, $sformatf("R%0d vector %0d", rq, i));
      endcase
    end
    idle();

    // R2: engine-side read ports
    eng_tx_addr = 4'd1; eng_cmd_addr = 4'd0; #1;
    check(eng_tx_data == 16'hABCD, "R2 engine tx port", eng_tx_data, 16'hABCD);
    check(eng_cmd_data == 8'hA5, "R6 engine cmd port", {8'd0, eng_cmd_data}, 16'h00A5);
    eng_cmd_addr = 4'd15; #1;
    check(eng_cmd_data == 8'h12, "R6 engine cmd last entry", {8'd0, eng_cmd_data}, 16'h0012);

    // R10: read collides with engine write in its capture cycle
    wr_op(1'b0, 16'h0013);
    wr_op(1'b1, 16'h1111);
    wr_op(1'b0, 16'h0013);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_reg = 1;
    eng_rx_we = 1; eng_rx_addr = 4'd3; eng_rx_wdata = 16'hBEEF;
    @(posedge clk); @(negedge clk);
    eng_rx_we = 0; #1;
    check(bus_rdata == 16'hBEEF, "R10 read forwarding", bus_rdata, 16'hBEEF);
    @(posedge clk);

    // R10: simultaneous CPU and engine write, engine wins
    wr_op(1'b0, 16'h0014);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_reg = 1; bus_wdata = 16'h2222;
    eng_rx_we = 1; eng_rx_addr = 4'd4; eng_rx_wdata = 16'h3333;
    @(posedge clk); @(negedge clk);
    eng_rx_we = 0; bus_sel = 0;
    wr_op(1'b0, 16'h0014);
    rd_op(1'b1, 16'h3333, "R10 engine write priority");
    rd_op(1'b0, 16'h0015, "R4 pointer after read");
    idle();

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule